// File: doc/BRIEF.md
# Register-Driven Buffer Test Engine

This block is a memory-mapped test peripheral. A host programs a small bank of word registers (scratch, command, status, source address, destination address, transfer size, checksum, interrupt type, interrupt number) and then writes the command register to launch a single operation. The operation is one of four kinds: pull words from a host buffer, push a generated pattern into a host buffer, copy one host buffer into another, or raise an interrupt directly.

Data moves over a word-wide request/acknowledge memory port. Each word is one handshake. While the engine runs, it folds every moved word into an XOR checksum. At the end it records success or failure and any address faults in the status word. After every transfer it signals completion through either a legacy pulse or a numbered message interrupt.

Top module: `bte_engine`

## Requirements
- R1: Register indices on `reg_addr` are 0 scratch, 1 command, 2 status, 3 source, 4 destination, 5 size (in words), 6 checksum, 7 interrupt type, 8 interrupt number. Every register reads zero after reset. Scratch reads back exactly the last value written.
- R2: The command bits are 0 legacy interrupt, 1 message interrupt, 2 extended message (reserved), 3 read, 4 write, 5 copy. When several bits are set, priority is read, then write, then copy, then message, then legacy. A command with only bit 2 set starts nothing and leaves status, checksum and the memory port untouched.
- R3: A read fetches `size` words from consecutive word addresses starting at the source address. It sets status bit 0 and leaves the XOR of the fetched words in the checksum.
- R4: A write stores the value PAT_BASE+i into word i at the destination. It sets status bit 2, and the checksum is the XOR of those stored values.
- R5: A copy moves `size` words from source to destination, alternating one read and one write. It sets status bit 4, and the checksum is the XOR of the moved words. A memory request stays asserted until it is acknowledged.
- R6: A transfer with size 0 issues no memory request, sets its success bit and leaves the checksum at 0.
- R7: An address is valid only when it is word aligned and lies in [WIN_BASE, WIN_BASE+WIN_BYTES). A bad source sets status bit 7 and a bad destination sets bit 8. Either one also sets the operation's fail bit (1 read, 3 write, 5 copy), and no memory request is made.
- R8: A legacy interrupt fires only when the interrupt number is 0. A message interrupt fires only when the number is in 1..32, and its vector equals that number. Status bit 6 is set exactly when an interrupt fires.
- R9: After each transfer, whether it succeeds or fails, exactly one interrupt is attempted. Interrupt type 0 selects legacy, type 1 selects message, and any other type raises none. Commands 0 and 1 attempt their own kind regardless of the type register. The legacy and message outputs are single-cycle pulses and are never high together.
- R10: A command write while an operation runs is ignored. The command register holds the running command and reads 0 once the operation completes.
- R11: Writing 1 to a status bit clears it. Starting a new command clears all nine result bits (0..8) and the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| intx_pulse | output | 1 | Legacy interrupt pulse |
| msg_valid | output | 1 | Message interrupt pulse |
| msg_vector | output | 6 | Message interrupt number |

## Verification
The bench targets several address corners:
- A source one byte off alignment.
- A destination just below the window.
- A destination at the last word of the window.
- A copy where both addresses are bad.

An engine that checked only one end, or that still touched memory, would show a wrong status or a nonzero request count. Interrupt numbers 0, 1, 32 and 33 are covered, along with a legacy request carrying a nonzero number and an out-of-range type. These expose an off-by-one in the range test or a pulse on the wrong line. The bench also fires a second command into a long stalled read, sends a reserved-only command and mixes command bits. A sequencer that restarted, wrote memory or picked the wrong operation would corrupt the checksum or the status.

// File: rtl/bte_pkg.sv
package bte_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_IRQ} st_e;
  typedef enum logic [2:0] {OP_NONE, OP_RD, OP_WR, OP_CP, OP_MSG, OP_LEG} op_e;
  typedef enum logic [1:0] {K_LEG, K_MSG, K_NONE} irq_kind_e;

  localparam int RI_SCRATCH = 0;
  localparam int RI_CMD     = 1;
  localparam int RI_STAT    = 2;
  localparam int RI_SRC     = 3;
  localparam int RI_DST     = 4;
  localparam int RI_SIZE    = 5;
  localparam int RI_CSUM    = 6;
  localparam int RI_ITYPE   = 7;
  localparam int RI_INUM    = 8;

  localparam int CB_LEG = 0;
  localparam int CB_MSG = 1;
  localparam int CB_RD  = 3;
  localparam int CB_WR  = 4;
  localparam int CB_CP  = 5;
  localparam int CMD_W  = 6;

  localparam int SB_RD_OK  = 0;
  localparam int SB_RD_BAD = 1;
  localparam int SB_WR_OK  = 2;
  localparam int SB_WR_BAD = 3;
  localparam int SB_CP_OK  = 4;
  localparam int SB_CP_BAD = 5;
  localparam int SB_IRQ    = 6;
  localparam int SB_SRC_IV = 7;
  localparam int SB_DST_IV = 8;
  localparam int STAT_W    = 9;

  localparam int MSG_MAX = 32;
endpackage

// File: rtl/bte_addr_chk.sv
module bte_addr_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE  = 'h1000,
  parameter logic [AW-1:0] BYTES = 'h400
) (
  input  logic [AW-1:0] addr,
  output logic          ok
);
  logic [AW-1:0] off;
  always_comb begin
    off = addr - BASE;
    ok  = (addr[1:0] == 2'b00) && (addr >= BASE) && (off < BYTES);
  end
endmodule

// File: rtl/bte_irq.sv
module bte_irq import bte_pkg::*; #(
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  irq_kind_e        kind,
  input  logic [NUM_W-1:0] num,
  output logic             raised,
  output logic             intx_pulse,
  output logic             msg_valid,
  output logic [NUM_W-1:0] msg_vector
);
  logic leg_ok, msg_ok;
  logic intx_d, msg_d;
  logic [NUM_W-1:0] vec_d;

  always_comb begin
    leg_ok = fire && (kind == K_LEG) && (num == '0);
    msg_ok = fire && (kind == K_MSG) && (num != '0) && (num <= NUM_W'(MSG_MAX));
    raised = leg_ok || msg_ok;
    intx_d = leg_ok;
    msg_d  = msg_ok;
    vec_d  = msg_ok ? num : msg_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intx_pulse <= 1'b0;
      msg_valid  <= 1'b0;
      msg_vector <= '0;
    end else begin
      intx_pulse <= intx_d;
      msg_valid  <= msg_d;
      msg_vector <= vec_d;
    end
  end

  p_single_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(intx_pulse && msg_valid));
  p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_vector != '0) && (msg_vector <= NUM_W'(MSG_MAX)));
  p_pulse_from_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_pulse || msg_valid) |-> $past(fire));
endmodule

// File: rtl/bte_engine.sv
module bte_engine import bte_pkg::*; #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int RA_W  = 4,
  parameter int SZ_W  = 16,
  parameter int NUM_W = 6,
  parameter logic [AW-1:0] WIN_BASE  = 'h1000,
  parameter logic [AW-1:0] WIN_BYTES = 'h400,
  parameter logic [DW-1:0] PAT_BASE  = 'hC0DE_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             intx_pulse,
  output logic             msg_valid,
  output logic [NUM_W-1:0] msg_vector
);
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  logic [DW-1:0]     scratch_q, csum_q, csum_d, hold_q, hold_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d, cmd_w;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [AW-1:0]     src_q, dst_q;
  logic [SZ_W-1:0]   size_q, cnt_q, cnt_d;
  logic [1:0]        itype_q;
  logic [NUM_W-1:0]  inum_q;
  st_e               st_q, st_d;
  op_e               op_q, op_d, op_new;
  irq_kind_e         kind_q, kind_d;
  logic              src_ok, dst_ok, fire, raised, last, start;
  logic [DW-1:0]     pattern;

  bte_addr_chk #(.AW(AW), .BASE(WIN_BASE), .BYTES(WIN_BYTES)) u_src_chk (.addr(src_q), .ok(src_ok));
  bte_addr_chk #(.AW(AW), .BASE(WIN_BASE), .BYTES(WIN_BYTES)) u_dst_chk (.addr(dst_q), .ok(dst_ok));

  bte_irq #(.NUM_W(NUM_W)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .kind(kind_q), .num(inum_q),
    .raised(raised), .intx_pulse(intx_pulse), .msg_valid(msg_valid), .msg_vector(msg_vector));

  function automatic logic wr_at(input int idx);
    return reg_wr && (reg_addr == RA_W'(idx));
  endfunction

  always_comb begin
    cmd_w = reg_wdata[CMD_W-1:0];
    if      (cmd_w[CB_RD])  op_new = OP_RD;
    else if (cmd_w[CB_WR])  op_new = OP_WR;
    else if (cmd_w[CB_CP])  op_new = OP_CP;
    else if (cmd_w[CB_MSG]) op_new = OP_MSG;
    else if (cmd_w[CB_LEG]) op_new = OP_LEG;
    else                    op_new = OP_NONE;
    start   = wr_at(RI_CMD) && (st_q == ST_IDLE) && (op_new != OP_NONE);
    last    = (cnt_q == size_q - 1'b1);
    pattern = PAT_BASE + DW'(cnt_q);
    mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
    mem_we    = (st_q == ST_WR);
    mem_addr  = ((st_q == ST_WR) ? dst_q : src_q) + AW'({cnt_q, 2'b00});
    mem_wdata = (op_q == OP_WR) ? pattern : hold_q;
  end

  always_comb begin
    st_d = st_q; op_d = op_q; cnt_d = cnt_q; hold_d = hold_q;
    csum_d = csum_q; cmd_d = cmd_q; kind_d = kind_q; fire = 1'b0;
    stat_d = stat_q;
    if (wr_at(RI_STAT)) stat_d = stat_q & ~reg_wdata[STAT_W-1:0];
    case (st_q)
      ST_IDLE: if (start) begin
        cmd_d = cmd_w; stat_d = '0; csum_d = '0; cnt_d = '0; op_d = op_new;
        if (op_new == OP_LEG)      kind_d = K_LEG;
        else if (op_new == OP_MSG) kind_d = K_MSG;
        else if (itype_q == 2'd0)  kind_d = K_LEG;
        else if (itype_q == 2'd1)  kind_d = K_MSG;
        else                       kind_d = K_NONE;
        st_d = ST_IRQ;
        case (op_new)
          OP_RD: begin
            if (!src_ok) begin stat_d[SB_SRC_IV] = 1'b1; stat_d[SB_RD_BAD] = 1'b1; end
            else if (size_q == '0) stat_d[SB_RD_OK] = 1'b1;
            else st_d = ST_RD;
          end
          OP_WR: begin
            if (!dst_ok) begin stat_d[SB_DST_IV] = 1'b1; stat_d[SB_WR_BAD] = 1'b1; end
            else if (size_q == '0) stat_d[SB_WR_OK] = 1'b1;
            else st_d = ST_WR;
          end
          OP_CP: begin
            if (!src_ok || !dst_ok) begin
              stat_d[SB_SRC_IV] = !src_ok; stat_d[SB_DST_IV] = !dst_ok;
              stat_d[SB_CP_BAD] = 1'b1;
            end
            else if (size_q == '0) stat_d[SB_CP_OK] = 1'b1;
            else st_d = ST_RD;
          end
          default: ;
        endcase
      end
      ST_RD: if (mem_ack) begin
        csum_d = csum_q ^ mem_rdata;
        hold_d = mem_rdata;
        if (op_q == OP_CP) st_d = ST_WR;
        else begin
          cnt_d = cnt_q + 1'b1;
          if (last) begin stat_d[SB_RD_OK] = 1'b1; st_d = ST_IRQ; end
        end
      end
      ST_WR: if (mem_ack) begin
        if (op_q == OP_WR) csum_d = csum_q ^ pattern;
        cnt_d = cnt_q + 1'b1;
        if (last) begin
          if (op_q == OP_WR) stat_d[SB_WR_OK] = 1'b1;
          else               stat_d[SB_CP_OK] = 1'b1;
          st_d = ST_IRQ;
        end else if (op_q == OP_CP) st_d = ST_RD;
      end
      ST_IRQ: begin
        fire = 1'b1;
        if (raised) stat_d[SB_IRQ] = 1'b1;
        cmd_d = '0;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      scratch_q <= '0; src_q <= '0; dst_q <= '0; size_q <= '0;
      itype_q <= '0; inum_q <= '0; cmd_q <= '0; stat_q <= '0; csum_q <= '0;
      hold_q <= '0; cnt_q <= '0; st_q <= ST_IDLE; op_q <= OP_NONE; kind_q <= K_NONE;
    end else begin
      if (wr_at(RI_SCRATCH)) scratch_q <= reg_wdata;
      if (wr_at(RI_SRC))     src_q     <= reg_wdata[AW-1:0];
      if (wr_at(RI_DST))     dst_q     <= reg_wdata[AW-1:0];
      if (wr_at(RI_SIZE))    size_q    <= reg_wdata[SZ_W-1:0];
      if (wr_at(RI_ITYPE))   itype_q   <= reg_wdata[1:0];
      if (wr_at(RI_INUM))    inum_q    <= reg_wdata[NUM_W-1:0];
      cmd_q <= cmd_d; stat_q <= stat_d; csum_q <= csum_d; hold_q <= hold_d;
      cnt_q <= cnt_d; st_q <= st_d; op_q <= op_d; kind_q <= kind_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_W'(RI_SCRATCH): reg_rdata = scratch_q;
      RA_W'(RI_CMD):     reg_rdata = DW'(cmd_q);
      RA_W'(RI_STAT):    reg_rdata = DW'(stat_q);
      RA_W'(RI_SRC):     reg_rdata = DW'(src_q);
      RA_W'(RI_DST):     reg_rdata = DW'(dst_q);
      RA_W'(RI_SIZE):    reg_rdata = DW'(size_q);
      RA_W'(RI_CSUM):    reg_rdata = csum_q;
      RA_W'(RI_ITYPE):   reg_rdata = DW'(itype_q);
      RA_W'(RI_INUM):    reg_rdata = DW'(inum_q);
      default:           reg_rdata = '0;
    endcase
  end

  p_req_aligned_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ack) |=> mem_req);
  p_cmd_busy_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && wr_at(RI_CMD)) |=> $stable(cmd_q));
endmodule

// File: tb/sim_bte_engine.sv
module sim_bte_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic intx_pulse, msg_valid;
  logic [5:0] msg_vector;

  always #(CLK_PERIOD/2) clk = ~clk;

  bte_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .intx_pulse(intx_pulse), .msg_valid(msg_valid), .msg_vector(msg_vector));

  logic [31:0] mem [0:255];
  logic [31:0] off;
  logic [7:0]  idx;
  logic stall, tog;
  int req_cnt, wr_cnt, intx_cnt, msg_cnt;
  logic [5:0] last_vec;

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h0101_0101) ^ 32'h5A00_0000;
  endfunction

  assign off       = mem_addr - 32'h1000;
  assign idx       = off[9:2];
  assign mem_rdata = mem[idx];
  assign mem_ack   = mem_req && (!stall || tog);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      tog <= 1'b0; req_cnt <= 0; wr_cnt <= 0; intx_cnt <= 0; msg_cnt <= 0; last_vec <= '0;
    end else begin
      tog <= ~tog;
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_req && mem_we && mem_ack) begin mem[idx] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      if (intx_pulse) intx_cnt <= intx_cnt + 1;
      if (msg_valid) begin msg_cnt <= msg_cnt + 1; last_vec <= msg_vector; end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_addr = 4'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] c;
    for (int k = 0; k < 4000; k++) begin
      reg_read(1, c);
      if (c == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [5:0]  cmd;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] size;
    logic [1:0]  ityp;
    logic [5:0]  inum;
    logic [8:0]  st;
    logic        stl;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{6'h08, 32'h1000, 32'h0000, 16'd4, 2'd0, 6'd0,  9'h041, 1'b0},
    '{6'h10, 32'h0000, 32'h1100, 16'd3, 2'd1, 6'd5,  9'h044, 1'b1},
    '{6'h20, 32'h1000, 32'h1200, 16'd5, 2'd1, 6'd32, 9'h050, 1'b1},
    '{6'h08, 32'h1002, 32'h0000, 16'd2, 2'd0, 6'd0,  9'h0C2, 1'b0},
    '{6'h10, 32'h0000, 32'h2000, 16'd2, 2'd1, 6'd1,  9'h148, 1'b0},
    '{6'h20, 32'h1000, 32'h0FFC, 16'd2, 2'd0, 6'd0,  9'h160, 1'b0},
    '{6'h20, 32'h1010, 32'h1240, 16'd2, 2'd1, 6'd33, 9'h010, 1'b1},
    '{6'h08, 32'h1000, 32'h0000, 16'd0, 2'd0, 6'd0,  9'h041, 1'b0},
    '{6'h02, 32'h0000, 32'h0000, 16'd0, 2'd0, 6'd7,  9'h040, 1'b0},
    '{6'h01, 32'h0000, 32'h0000, 16'd0, 2'd1, 6'd0,  9'h040, 1'b0},
    '{6'h08, 32'h1004, 32'h0000, 16'd3, 2'd0, 6'd3,  9'h001, 1'b1},
    '{6'h20, 32'h1001, 32'h3000, 16'd1, 2'd0, 6'd0,  9'h1E0, 1'b0},
    '{6'h18, 32'h1020, 32'h1300, 16'd2, 2'd0, 6'd0,  9'h041, 1'b0},
    '{6'h10, 32'h0000, 32'h13FC, 16'd1, 2'd2, 6'd0,  9'h004, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired (R10 completion)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, ecs, snap_req, snap_wr, snap_ix, snap_msg;
    logic [31:0] srcw [0:63];
    bit exp_msg, exp_ix, fail_op, mem_ok;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; stall = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 / R11: reset values
    for (int a = 0; a <= 8; a++) begin
      reg_read(a, rd);
      chk("R1", $sformatf("reset reg %0d", a), rd, 32'h0);
    end
    // R1: scratch read-back
    reg_write(0, 32'hDEAD_BEEF); reg_read(0, rd); chk("R1", "scratch A", rd, 32'hDEAD_BEEF);
    reg_write(0, 32'h0123_4567); reg_read(0, rd); chk("R1", "scratch B", rd, 32'h0123_4567);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VT[v];
      reg_write(3, t.src); reg_write(4, t.dst); reg_write(5, 32'(t.size));
      reg_write(7, 32'(t.ityp)); reg_write(8, 32'(t.inum));
      fail_op = t.st[1] || t.st[3] || t.st[5];
      ecs = 0;
      for (int i = 0; i < int'(t.size); i++) begin
        srcw[i] = mem[(t.src - 32'h1000) >> 2 & 32'hFF];
        if (!fail_op) ecs ^= (t.cmd[3] || t.cmd[5]) ? srcw[i] : PAT + 32'(i);
      end
      if (!(t.cmd[3] || t.cmd[4] || t.cmd[5])) ecs = 0;
      else if (t.cmd[3]) begin
        ecs = 0;
        if (!fail_op) for (int i = 0; i < int'(t.size); i++) ecs ^= mem[(t.src + 32'(4*i) - 32'h1000) >> 2 & 32'hFF];
      end else if (t.cmd[5]) begin
        ecs = 0;
        for (int i = 0; i < int'(t.size); i++) srcw[i] = mem[(t.src + 32'(4*i) - 32'h1000) >> 2 & 32'hFF];
        if (!fail_op) for (int i = 0; i < int'(t.size); i++) ecs ^= srcw[i];
      end
      exp_msg = t.st[6] && (t.cmd == 6'h02 || ((t.cmd[5:3] != 0) && t.ityp == 2'd1));
      exp_ix  = t.st[6] && !exp_msg;
      stall = t.stl;
      snap_req = req_cnt; snap_wr = wr_cnt; snap_ix = intx_cnt; snap_msg = msg_cnt;
      reg_write(1, 32'(t.cmd));
      wait_done();
      reg_read(2, rd); chk(t.st[8:7] != 0 ? "R7" : "R11", $sformatf("vec %0d status", v), rd, 32'(t.st));
      reg_read(6, rd); chk(t.cmd[4] ? "R4" : "R3", $sformatf("vec %0d checksum", v), rd, ecs);
      chk("R9", $sformatf("vec %0d legacy count", v), intx_cnt - snap_ix, 32'(exp_ix));
      chk("R8", $sformatf("vec %0d message count", v), msg_cnt - snap_msg, 32'(exp_msg));
      if (exp_msg) chk("R8", $sformatf("vec %0d vector", v), 32'(last_vec), 32'(t.inum));
      if (fail_op || t.size == 0 || t.cmd[2:0] != 0)
        chk(t.size == 0 ? "R6" : "R7", $sformatf("vec %0d no access", v), req_cnt - snap_req, 32'h0);
      else if (t.cmd[4] && !t.cmd[3] || t.cmd[5] && !t.cmd[3]) begin
        mem_ok = 1;
        for (int i = 0; i < int'(t.size); i++)
          if (mem[(t.dst + 32'(4*i) - 32'h1000) >> 2 & 32'hFF] !== (t.cmd[4] ? PAT + 32'(i) : srcw[i])) mem_ok = 0;
        chk(t.cmd[4] ? "R4" : "R5", $sformatf("vec %0d dest data", v), 32'(mem_ok), 32'h1);
      end else chk("R2", $sformatf("vec %0d no writes", v), wr_cnt - snap_wr, 32'h0);
    end

    // R2: reserved-only command has no effect (status is 0x004 from last vector)
    snap_req = req_cnt; snap_ix = intx_cnt; snap_msg = msg_cnt;
    reg_write(1, 32'h04);
    repeat (4) @(negedge clk);
    reg_read(1, rd); chk("R2", "reserved cmd readback", rd, 32'h0);
    reg_read(2, rd); chk("R2", "reserved cmd status", rd, 32'h004);
    chk("R2", "reserved cmd activity", (req_cnt - snap_req) + (intx_cnt - snap_ix) + (msg_cnt - snap_msg), 32'h0);

    // R10: command written during a busy read is ignored
    reg_write(3, 32'h1000); reg_write(4, 32'h1300); reg_write(5, 32'd40);
    reg_write(7, 32'd0); reg_write(8, 32'd0);
    ecs = 0;
    for (int i = 0; i < 40; i++) ecs ^= mem[i];
    stall = 1; snap_wr = wr_cnt;
    reg_write(1, 32'h08);
    reg_write(1, 32'h20);
    reg_read(1, rd); chk("R10", "cmd while busy", rd, 32'h08);
    wait_done();
    reg_read(1, rd); chk("R10", "cmd self-clear", rd, 32'h0);
    reg_read(2, rd); chk("R10", "busy status", rd, 32'h041);
    reg_read(6, rd); chk("R3", "long read checksum", rd, ecs);
    chk("R10", "no copy writes", wr_cnt - snap_wr, 32'h0);

    // R11: write-one-to-clear
    reg_write(2, 32'h001); reg_read(2, rd); chk("R11", "w1c bit0", rd, 32'h040);
    reg_write(2, 32'h040); reg_read(2, rd); chk("R11", "w1c bit6", rd, 32'h000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule